// File: doc/BRIEF.md
# Biphase-mark time code data and clock recovery

This block takes a longitudinal time code stream in biphase-mark form, already squared to logic levels, and recovers the data and a bit clock from it. A fast master clock samples the stream. Every cell boundary carries a transition, and a logic one adds one more transition in mid-cell. The block measures the spacing between transitions in master-clock cycles and keeps a running estimate of the cell length. This lets it follow tape speed from a crawl (about 1/100 of play speed) to fast wind (about 300 times play speed).

The recovered data and bit clock are meant to be shifted into a shift register or a synchronous serial receiver. The bit clock goes high for the last quarter of each cell, and its rising edge is the latch point. During a cell the data output is low for the first half and shows the bit decoded from the previous cell for the second half. Two diagnostic pulses show that the block sees input edges and finds cell boundaries. An active-low flag reports a stalled input.

The master clock is nominally 12.288 MHz. The default stall limit of 516096 cycles is about 42 ms at that clock, and every timing limit scales with the clock frequency.

Top module: `bmark_sep`

## Requirements
- R1: Each transition of `line_i` is passed through a two-flop synchroniser. `edge_o` then goes high from the third rising clock edge after the change and stays high for `EDGE_PULSE` cycles (default 8). A further transition inside that window restarts the window.
- R2: Every detected cell boundary drives `mark_o` high for exactly `MARK_PULSE` cycles (default 2), starting one cycle after the boundary is detected. No other event raises `mark_o`.
- R3: A cell with no mid-cell transition decodes as 0. A cell with a mid-cell transition decodes as 1. A cell's bit is present on `data_o` at the rising edge of `bclk_o` during the following cell.
- R4: Let the previous cell be L cycles long, and count the cycles after a boundary with k = 1 for the first cycle. `data_o` is 0 while 2k < L and equals the decoded bit once 2k >= L.
- R5: `bclk_o` rises at the first k with 4k >= 3L and stays high until the next boundary or a stall.
- R6: An interval I between transitions is a half cell when 4*I < 3*E, where E is the running cell estimate; otherwise it is a full cell. E becomes the interval itself after a full cell, or the sum of a pair of half cells after the second of the pair.
- R7: `slow_n_o` goes low when `SLOW_LIMIT` cycles have passed since the last synchronised transition. It goes high again from the third rising clock edge after the next input change. The interval counter saturates at the limit and does not wrap.
- R8: While stalled, `data_o` and `bclk_o` are low. After reset or a stall, the first transition only starts timing. The second transition is always taken as the end of a 0 cell, and that interval seeds E.
- R9: In reset, `data_o`, `bclk_o`, `edge_o` and `mark_o` are 0 and `slow_n_o` is 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Master sampling clock |
| rst_n | input | 1 | Active-low synchronous reset |
| line_i | input | 1 | Squared biphase-mark time code stream (asynchronous) |
| data_o | output | 1 | Recovered NRZ data; low in first half of the cell, bit in the second half |
| bclk_o | output | 1 | Recovered bit clock; high for the last quarter of the cell |
| edge_o | output | 1 | Diagnostic pulse after every input transition |
| mark_o | output | 1 | Diagnostic pulse at every detected cell boundary |
| slow_n_o | output | 1 | Active-low flag: input stalled beyond the timeout |

## Verification
The assertions check five things on every cycle:
- an edge pulse follows each synchronised transition;
- `mark_o` rises only after a boundary and always follows one;
- the bit clock falls only at a boundary or a stall;
- the stall flag clears after a transition;
- data and bit clock stay quiet through a stall.

Other behaviour can only be shown by the bench scenarios:
- the decoded bit values;
- the exact half-cell and three-quarter positions for each cell length;
- the half/full threshold at exactly 3/4 of the estimate;
- estimate tracking across a speed ramp;
- the exact cycle on which the stall flag asserts.

The bench shows these by sweeping many cell lengths and bit patterns, plus a dedicated threshold stream.

// File: rtl/bmark_sep.sv
module bmark_sep #(
  parameter int SLOW_LIMIT = 516096,
  parameter int EDGE_PULSE = 8,
  parameter int MARK_PULSE = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic line_i,
  output logic data_o,
  output logic bclk_o,
  output logic edge_o,
  output logic mark_o,
  output logic slow_n_o
);

  localparam int GW = $clog2(SLOW_LIMIT + 1);
  localparam int EW = GW + 1;
  localparam int PW = $clog2(EDGE_PULSE + 1);
  localparam int MW = $clog2(MARK_PULSE + 1);
  localparam logic [GW-1:0] LIM = GW'(SLOW_LIMIT);

  logic [2:0]    sync_q;
  logic [GW-1:0] gap_q, h1_q;
  logic [EW-1:0] est_q, phase_q, nest;
  logic [PW-1:0] ep_q;
  logic [MW-1:0] mk_q;
  logic          armed_q, seeded_q, pend_q, locked_q, bit_q;
  logic          bnd, nbit;

  wire tog     = sync_q[1] ^ sync_q[2];
  wire stall   = (gap_q == LIM);
  wire restart = tog & (~armed_q | stall);
  wire measure = tog & armed_q & ~stall;

  wire [EW+1:0] gap_x4 = {1'b0, gap_q, 2'b00};
  wire [EW+1:0] est_x3 = {2'b00, est_q} + {1'b0, est_q, 1'b0};
  wire          is_half = seeded_q & (gap_x4 < est_x3);

  always_comb begin
    bnd  = 1'b0;
    nbit = 1'b0;
    nest = est_q;
    if (measure) begin
      if (!is_half) begin
        bnd  = 1'b1;
        nest = {1'b0, gap_q};
      end else if (pend_q) begin
        bnd  = 1'b1;
        nbit = 1'b1;
        nest = {1'b0, gap_q} + {1'b0, h1_q};
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sync_q   <= '0;
      gap_q    <= '0;
      h1_q     <= '0;
      est_q    <= '0;
      phase_q  <= '0;
      ep_q     <= '0;
      mk_q     <= '0;
      armed_q  <= 1'b0;
      seeded_q <= 1'b0;
      pend_q   <= 1'b0;
      locked_q <= 1'b0;
      bit_q    <= 1'b0;
    end else begin
      sync_q <= {sync_q[1:0], line_i};

      if (tog)        gap_q <= GW'(1);
      else if (!stall) gap_q <= gap_q + 1'b1;

      if (restart)    armed_q <= 1'b1;
      else if (stall) armed_q <= 1'b0;

      if (restart)  seeded_q <= 1'b0;
      else if (bnd) seeded_q <= 1'b1;

      if (restart)      pend_q <= 1'b0;
      else if (measure) pend_q <= is_half & ~pend_q;

      if (measure && is_half && !pend_q) h1_q <= gap_q;

      if (bnd) begin
        est_q <= nest;
        bit_q <= nbit;
      end

      if (bnd)        locked_q <= 1'b1;
      else if (stall) locked_q <= 1'b0;

      if (bnd)                      phase_q <= EW'(1);
      else if (locked_q && !(&phase_q)) phase_q <= phase_q + 1'b1;

      if (tog)            ep_q <= PW'(EDGE_PULSE);
      else if (ep_q != 0) ep_q <= ep_q - 1'b1;

      if (bnd)            mk_q <= MW'(MARK_PULSE);
      else if (mk_q != 0) mk_q <= mk_q - 1'b1;
    end
  end

  assign data_o   = locked_q & bit_q & ({phase_q, 1'b0} >= {1'b0, est_q});
  assign bclk_o   = locked_q & ({phase_q, 2'b00} >= est_x3);
  assign edge_o   = (ep_q != 0);
  assign mark_o   = (mk_q != 0);
  assign slow_n_o = ~stall;

endmodule

// File: rtl/bmark_sep_chk.sv
module bmark_sep_chk (
  input logic clk,
  input logic rst_n,
  input logic tog,
  input logic bnd,
  input logic stall,
  input logic data_o,
  input logic bclk_o,
  input logic edge_o,
  input logic mark_o,
  input logic slow_n_o
);

  // R1
  edge_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(tog) |-> edge_o);

  // R2
  mark_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(bnd) |-> mark_o);

  // R2
  mark_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mark_o) |-> $past(bnd));

  // R5
  bclk_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(bclk_o) |-> ($past(bnd) || $past(stall)));

  // R7
  slow_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(tog) |-> slow_n_o);

  // R8
  stall_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!slow_n_o && !$past(slow_n_o)) |-> (!bclk_o && !data_o));

endmodule

bind bmark_sep bmark_sep_chk u_chk (
  .clk(clk), .rst_n(rst_n), .tog(tog), .bnd(bnd), .stall(stall),
  .data_o(data_o), .bclk_o(bclk_o), .edge_o(edge_o), .mark_o(mark_o),
  .slow_n_o(slow_n_o)
);

// File: tb/bmark_sep_tb.sv
module bmark_sep_tb;
  localparam int CLK_PERIOD = 10;
  localparam int LIMIT = 3000;
  localparam int EPW = 8;
  localparam int MPW = 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic rx = 1'b0;
  logic data_o, bclk_o, edge_o, mark_o, slow_n_o;

  always #(CLK_PERIOD/2) clk = ~clk;

  bmark_sep #(.SLOW_LIMIT(LIMIT), .EDGE_PULSE(EPW), .MARK_PULSE(MPW)) u_dut (
    .clk(clk), .rst_n(rst_n), .line_i(rx), .data_o(data_o), .bclk_o(bclk_o),
    .edge_o(edge_o), .mark_o(mark_o), .slow_n_o(slow_n_o));

  int len_a [0:63];
  int mid_a [0:63];
  int bits_a [0:63];
  int run_id = 0;
  bit active = 1'b0;
  int chk = 0, fails = 0;

  // monitor
  int cyc = 0, mcyc = 0, mi = 0, ridx = 0, hw = 0, seen_run = 0;
  int mchk = 0, mfail = 0;
  logic pm = 1'b0, pb = 1'b0;

  always @(negedge clk) begin
    int idx, L, d;
    cyc++;
    if (run_id != seen_run) begin
      seen_run = run_id; mi = 0; ridx = 0;
    end
    if (mark_o && !pm) begin
      mcyc = cyc; mi++;
    end
    if (mark_o) hw++;
    else if (pm) begin
      mchk++;
      if (hw != MPW) begin
        mfail++; $display("FAIL R2 mark width got %0d exp %0d", hw, MPW);
      end
      hw = 0;
    end
    if (active && mi > 0 && rst_n) begin
      idx = mi - 1; L = len_a[idx]; d = cyc - mcyc;
      if (d == L/2 - 2) begin
        mchk++;
        if (data_o !== 1'b0) begin
          mfail++; $display("FAIL R4 cell %0d early data got %0d exp 0", idx, data_o);
        end
      end
      if (d == L/2 - 1) begin
        mchk++;
        if (data_o !== bits_a[idx][0]) begin
          mfail++; $display("FAIL R4 cell %0d half data got %0d exp %0d", idx, data_o, bits_a[idx]);
        end
      end
      if (bclk_o && !pb) begin
        mchk++;
        if (d != (3*L + 3)/4 - 1) begin
          mfail++; $display("FAIL R5 cell %0d bclk offset got %0d exp %0d", idx, d, (3*L+3)/4-1);
        end
        mchk++;
        if (data_o !== bits_a[idx][0]) begin
          mfail++; $display("FAIL R3 cell %0d bit got %0d exp %0d", idx, data_o, bits_a[idx]);
        end
        ridx++;
      end
    end
    pm = mark_o; pb = bclk_o;
  end

  task automatic check(input string req, input int got, input int exp);
    chk++;
    if (got != exp) begin
      fails++; $display("FAIL %s got %0d exp %0d", req, got, exp);
    end
  endtask

  task automatic play(input int n);
    run_id++;
    active = 1'b1;
    for (int i = 0; i < n; i++) begin
      rx = ~rx;
      if (mid_a[i] != 0) begin
        repeat (mid_a[i]) @(negedge clk);
        rx = ~rx;
        repeat (len_a[i] - mid_a[i]) @(negedge clk);
      end else begin
        repeat (len_a[i]) @(negedge clk);
      end
    end
    rx = ~rx;
    repeat (len_a[n-1] + 4) @(negedge clk);
    active = 1'b0;
    check("R2 marks per run", mi, n);
    check("R3 bits per run", ridx, n);
    repeat (LIMIT + 4) @(negedge clk);
    check("R8 stalled slow_n", slow_n_o, 0);
    check("R8 stalled bclk", bclk_o, 0);
    check("R8 stalled data", data_o, 0);
  endtask

  task automatic set_cell(input int i, input int L, input int b);
    len_a[i] = L; bits_a[i] = b; mid_a[i] = b ? L/2 : 0;
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", chk + mchk + 1, fails + mfail + 1);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R9 reset state
    check("R9 data", data_o, 0);
    check("R9 bclk", bclk_o, 0);
    check("R9 edge", edge_o, 0);
    check("R9 mark", mark_o, 0);
    check("R9 slow_n", slow_n_o, 1);
    rst_n = 1'b1;
    @(negedge clk);

    // R3 R4 R5 sweep of cell lengths with pseudo-random bits
    for (int L = 12; L <= 64; L += 4) begin
      int st = L;
      set_cell(0, L, 0);
      for (int i = 1; i < 26; i++) begin
        st = (st * 5 + 17 + i) % 256;
        set_cell(i, L, (st >> 3) & 1);
      end
      play(26);
    end

    // R6 speed ramp down and up
    begin
      int k = 0;
      for (int L = 40; L >= 24; L -= 4) begin set_cell(k, L, k % 2 == 0 ? 0 : 1); k++; end
      for (int L = 28; L <= 44; L += 4) begin set_cell(k, L, k % 3 == 0 ? 1 : 0); k++; end
      bits_a[0] = 0; mid_a[0] = 0;
      play(k);
    end

    // R6 threshold: 29 of 40 is a half, 30 of 40 is full
    set_cell(0, 40, 0);
    len_a[1] = 40; mid_a[1] = 29; bits_a[1] = 1;
    set_cell(2, 40, 0);
    set_cell(3, 30, 0);
    set_cell(4, 30, 0);
    set_cell(5, 40, 0);
    set_cell(6, 40, 0);
    play(7);

    // R1 and R7 isolated edge timing, starting from a stall
    rx = ~rx;
    repeat (2) @(negedge clk);
    check("R1 edge before sync", edge_o, 0);
    check("R7 slow_n still low", slow_n_o, 0);
    @(negedge clk);
    check("R1 edge start", edge_o, 1);
    check("R7 slow_n released", slow_n_o, 1);
    repeat (7) @(negedge clk);
    check("R1 edge last cycle", edge_o, 1);
    @(negedge clk);
    check("R1 edge end", edge_o, 0);
    repeat (LIMIT + 1 - 11) @(negedge clk);
    check("R7 slow_n before limit", slow_n_o, 1);
    @(negedge clk);
    check("R7 slow_n at limit", slow_n_o, 0);
    repeat (50) @(negedge clk);
    check("R7 slow_n saturated", slow_n_o, 0);

    $display("[TB] %0d tests run, %0d failed", chk + mchk, fails + mfail);
    $finish;
  end
endmodule